// File: doc/BRIEF.md
# Clock-Correcting Receive Elastic Buffer

This block bridges a byte stream from a recovered write clock to a local read clock when the phase between the two clocks is unknown. Each symbol is a decoded byte with a control flag. It goes through a 64-entry dual-clock buffer whose pointers cross between the domains in Gray code through two-flop synchronizers. Each entry holds 13 bits: the byte, the control flag and a set of marks for clock correction.

The far end sends a four-symbol clock-correction pattern at intervals: 0xBC as a control symbol, then 0x95, 0xB5 and 0xB5 as data symbols. The write side recognizes the pattern only as a whole. If the buffer is more than three quarters full, the write side drops one complete pattern. If fewer than a quarter of the entries are unread, the read side plays one complete pattern a second time. With the strip input set, every symbol of a recognized pattern leaves the block with its valid flag low, so the user sees only payload. The sticky flags for overflow and underflow, and per-symbol pulses for inserted and removed patterns, tell the user what happened.

Top module: `ccbuf_top`

## Requirements
- R1: While either reset is held, and in the first cycle after it is released, rd_valid, rd_cc_ins, rd_cc_rem, rd_underflow and wr_overflow are all 0.
- R2: Symbols written with wr_valid=1 come out with rd_valid=1 in the same order, with the byte on rd_data and the control flag on rd_k intact.
- R3: A correction pattern counts only when four consecutive written symbols are 0xBC with wr_k=1, then 0x95, 0xB5 and 0xB5, each with wr_k=0. Any other four symbols, including a pattern with one byte or one control flag wrong, are never dropped, repeated or hidden.
- R4: When a pattern's first symbol is about to be stored and more than 48 entries (3/4 of 64) are stored, all four symbols are discarded. The next stored symbol carries a removed mark, and rd_cc_rem is 1 in the cycle that symbol is output. At exactly 48 stored entries the pattern is kept.
- R5: When the read side reaches a pattern's first symbol while fewer than 16 entries (1/4 of 64), and at least 4, are unread, it outputs the four symbols and then outputs them again. rd_cc_ins is 1 together with the repeated 0xBC, and the rest of the stream is unchanged.
- R6: With strip_en=1, every symbol of a recognized pattern, repeats included, is output with rd_valid=0. All other symbols are unaffected.
- R7: A symbol that reaches storage while 64 entries are held is lost. wr_overflow goes to 1 and stays 1 until wr_rst.
- R8: rd_underflow stays 0 until the first symbol has been read. After that it goes to 1 on any read cycle that finds the buffer empty, and it stays 1 until rd_rst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered (write) clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_valid | input | 1 | A symbol is present on wr_data/wr_k this cycle |
| wr_data | input | 8 | Decoded byte |
| wr_k | input | 1 | Byte is a control symbol |
| wr_overflow | output | 1 | Sticky: a symbol was lost to a full buffer |
| rd_clk | input | 1 | Local (read) clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| strip_en | input | 1 | Hide all correction-pattern symbols from the output |
| rd_valid | output | 1 | rd_data/rd_k carry a user symbol |
| rd_data | output | 8 | Output byte |
| rd_k | output | 1 | Output control flag |
| rd_cc_ins | output | 1 | Marks the first symbol of a repeated pattern |
| rd_cc_rem | output | 1 | Marks the symbol that follows a dropped pattern |
| rd_underflow | output | 1 | Sticky: buffer found empty after reading began |

## Verification
The hardest states to reach are the exact fill levels at which a pattern is judged, because with free-running clocks the fill drifts with synchronizer delay. The bench stops the read clock while it writes a burst of known length, which freezes the fill at 48, 49 or a few entries at the moment the pattern arrives. It then restarts the read clock and compares the whole output stream, the insert and remove pulses, and the index of the marked symbol against a model built from the written list. Broken patterns are sent under the same low-fill conditions that make a correct pattern repeat, so a decoder that matches loosely shows up as an extra repeat.

// File: rtl/ccb_pkg.sv
`timescale 1ns/1ps
package ccb_pkg;
  // correction pattern bytes; the first is a control symbol
  localparam logic [7:0] CC_B0 = 8'hBC;
  localparam logic [7:0] CC_B1 = 8'h95;
  localparam logic [7:0] CC_B2 = 8'hB5;

  // one stored entry: 13 bits
  typedef struct packed {
    logic       rem;     // a pattern was dropped just before this symbol
    logic       last;    // final symbol of a kept pattern
    logic       first;   // opening symbol of a kept pattern
    logic       member;  // symbol belongs to a kept pattern
    logic       k;
    logic [7:0] d;
  } ccb_word_t;
endpackage

// File: rtl/ccb_ram.sv
`timescale 1ns/1ps
module ccb_ram #(
  parameter int AW = 6,
  parameter int W  = 13
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ccb_sync.sv
`timescale 1ns/1ps
module ccb_sync #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_out[i] = ^(s2 >> i);
  end
endmodule

// File: rtl/ccb_wr.sv
`timescale 1ns/1ps
module ccb_wr
  import ccb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic            wr_clk,
  input  logic            wr_rst,
  input  logic            wr_valid,
  input  logic [7:0]      wr_data,
  input  logic            wr_k,
  input  logic [AW:0]     rd_bin,
  output logic            we,
  output logic [AW-1:0]   waddr,
  output ccb_word_t       wdata,
  output logic [AW:0]     wr_gray,
  output logic            wr_overflow
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] FULL_P = PW'(DEPTH);
  localparam logic [PW-1:0] HI_P   = PW'(DEPTH * 3 / 4);

  typedef struct packed {
    logic       v;
    logic [7:0] d;
    logic       k;
    logic       member;
    logic       last;
  } stage_t;

  stage_t        st [4];
  logic [PW-1:0] wr_ptr, ptr_nxt, fill;
  logic          rem_pend, match, hi, full, drop, push;

  // st[3] is the oldest symbol, st[0] the newest
  assign match = st[3].v && st[2].v && st[1].v && st[0].v &&
                 st[3].k  && st[3].d == CC_B0 &&
                 !st[2].k && st[2].d == CC_B1 &&
                 !st[1].k && st[1].d == CC_B2 &&
                 !st[0].k && st[0].d == CC_B2;

  assign fill    = wr_ptr - rd_bin;
  assign full    = (fill == FULL_P);
  assign hi      = (fill > HI_P);
  assign drop    = match && hi;
  assign push    = st[3].v && !drop;
  assign we      = push && !full;
  assign waddr   = wr_ptr[AW-1:0];
  assign ptr_nxt = wr_ptr + 1'b1;

  always_comb begin
    wdata.rem    = rem_pend;
    wdata.last   = st[3].last;
    wdata.first  = match;
    wdata.member = match || st[3].member;
    wdata.k      = st[3].k;
    wdata.d      = st[3].d;
  end

  always_ff @(posedge wr_clk) begin
    if (wr_rst) begin
      for (int i = 0; i < 4; i++) st[i] <= '0;
      wr_ptr      <= '0;
      wr_gray     <= '0;
      rem_pend    <= 1'b0;
      wr_overflow <= 1'b0;
    end else begin
      st[0] <= '{v: wr_valid, d: wr_data, k: wr_k, member: 1'b0, last: 1'b0};
      st[1] <= st[0];
      st[2] <= st[1];
      st[3] <= st[2];
      if (match) begin
        st[1].member <= 1'b1;
        st[1].last   <= 1'b1;
        st[2].member <= 1'b1;
        st[3].member <= 1'b1;
        if (drop) begin
          st[1].v <= 1'b0;
          st[2].v <= 1'b0;
          st[3].v <= 1'b0;
        end
      end
      if (we) begin
        wr_ptr  <= ptr_nxt;
        wr_gray <= ptr_nxt ^ (ptr_nxt >> 1);
      end
      if (push && full) wr_overflow <= 1'b1;
      if (drop)         rem_pend <= 1'b1;
      else if (we)      rem_pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ccb_rd.sv
`timescale 1ns/1ps
module ccb_rd
  import ccb_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          strip_en,
  input  logic [AW:0]   wr_bin,
  input  ccb_word_t     rdata,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rd_gray,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic          rd_k,
  output logic          rd_cc_ins,
  output logic          rd_cc_rem,
  output logic          rd_underflow
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam logic [PW-1:0] LO_P  = PW'(DEPTH / 4);
  localparam logic [PW-1:0] SEQ_P = PW'(4);

  typedef enum logic [1:0] {RS_PASS, RS_HOLD, RS_AGAIN} rstate_t;

  rstate_t       state;
  logic [PW-1:0] rd_addr, rel, rel_nxt, base, rep_a, avail;
  logic [1:0]    off;
  logic          started, empty, take, arm;

  assign avail   = wr_bin - rd_addr;
  assign empty   = (avail == '0);
  assign rep_a   = base + PW'(off);
  assign raddr   = (state == RS_AGAIN) ? rep_a[AW-1:0] : rd_addr[AW-1:0];
  assign take    = (state == RS_AGAIN) || !empty;
  assign arm     = (state == RS_PASS) && !empty && rdata.first &&
                   (avail < LO_P) && (avail >= SEQ_P);
  assign rel_nxt = rel + 1'b1;

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      state        <= RS_PASS;
      rd_addr      <= '0;
      rel          <= '0;
      rd_gray      <= '0;
      base         <= '0;
      off          <= '0;
      started      <= 1'b0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      rd_k         <= 1'b0;
      rd_cc_ins    <= 1'b0;
      rd_cc_rem    <= 1'b0;
      rd_underflow <= 1'b0;
    end else begin
      rd_valid  <= take && !(strip_en && rdata.member);
      rd_cc_rem <= take && rdata.rem;
      rd_cc_ins <= (state == RS_AGAIN) && (off == 2'd0);
      if (take) begin
        rd_data <= rdata.d;
        rd_k    <= rdata.k;
      end
      case (state)
        RS_PASS: begin
          if (!empty) begin
            rd_addr <= rd_addr + 1'b1;
            started <= 1'b1;
            if (arm) begin
              state <= RS_HOLD;
              base  <= rd_addr;
            end else begin
              rel     <= rel_nxt;
              rd_gray <= rel_nxt ^ (rel_nxt >> 1);
            end
          end else if (started) begin
            rd_underflow <= 1'b1;
          end
        end
        RS_HOLD: begin
          if (!empty) begin
            rd_addr <= rd_addr + 1'b1;
            if (rdata.last) begin
              state <= RS_AGAIN;
              off   <= '0;
            end
          end
        end
        RS_AGAIN: begin
          rel     <= rel_nxt;
          rd_gray <= rel_nxt ^ (rel_nxt >> 1);
          off     <= off + 1'b1;
          if (off == 2'd3) state <= RS_PASS;
        end
        default: state <= RS_PASS;
      endcase
    end
  end
endmodule

// File: rtl/ccbuf_top.sv
`timescale 1ns/1ps
module ccbuf_top
  import ccb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic       wr_clk,
  input  logic       wr_rst,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_k,
  output logic       wr_overflow,
  input  logic       rd_clk,
  input  logic       rd_rst,
  input  logic       strip_en,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  output logic       rd_k,
  output logic       rd_cc_ins,
  output logic       rd_cc_rem,
  output logic       rd_underflow
);
  localparam int PW = ADDR_W + 1;
  localparam int WW = $bits(ccb_word_t);

  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  ccb_word_t         wdata, rdata;
  logic [PW-1:0]     wr_gray, rd_gray, wr_bin_rd, rd_bin_wr;

  ccb_wr #(.AW(ADDR_W)) u_wr (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_k(wr_k), .rd_bin(rd_bin_wr),
    .we(we), .waddr(waddr), .wdata(wdata), .wr_gray(wr_gray),
    .wr_overflow(wr_overflow)
  );

  ccb_ram #(.AW(ADDR_W), .W(WW)) u_ram (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  ccb_sync #(.W(PW)) u_sync_w2r (
    .clk(rd_clk), .rst(rd_rst), .gray_in(wr_gray), .bin_out(wr_bin_rd)
  );

  ccb_sync #(.W(PW)) u_sync_r2w (
    .clk(wr_clk), .rst(wr_rst), .gray_in(rd_gray), .bin_out(rd_bin_wr)
  );

  ccb_rd #(.AW(ADDR_W)) u_rd (
    .rd_clk(rd_clk), .rd_rst(rd_rst), .strip_en(strip_en),
    .wr_bin(wr_bin_rd), .rdata(rdata), .raddr(raddr), .rd_gray(rd_gray),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_k(rd_k),
    .rd_cc_ins(rd_cc_ins), .rd_cc_rem(rd_cc_rem),
    .rd_underflow(rd_underflow)
  );
endmodule

// File: rtl/ccbuf_chk.sv
`timescale 1ns/1ps
module ccbuf_chk (
  input logic       wr_clk,
  input logic       wr_rst,
  input logic       wr_overflow,
  input logic       rd_clk,
  input logic       rd_rst,
  input logic       strip_en,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rd_k,
  input logic       rd_cc_ins,
  input logic       rd_cc_rem,
  input logic       rd_underflow
);
  // R1
  rd_reset_state_chk: assert property (@(posedge rd_clk)
    rd_rst |=> (!rd_valid && !rd_cc_ins && !rd_cc_rem && !rd_underflow));

  // R1
  wr_reset_state_chk: assert property (@(posedge wr_clk)
    wr_rst |=> !wr_overflow);

  // R7
  overflow_sticky_chk: assert property (@(posedge wr_clk) disable iff (wr_rst)
    wr_overflow |=> wr_overflow);

  // R8
  underflow_sticky_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_underflow |=> rd_underflow);

  // R5
  ins_on_pattern_head_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_cc_ins |-> (rd_k && rd_data == 8'hBC));

  // R5
  ins_single_pulse_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    rd_cc_ins |=> !rd_cc_ins);

  // R6
  strip_hides_repeat_chk: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (rd_cc_ins && $past(strip_en)) |-> !rd_valid);
endmodule

bind ccbuf_top ccbuf_chk u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_overflow(wr_overflow),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .strip_en(strip_en),
  .rd_valid(rd_valid), .rd_data(rd_data), .rd_k(rd_k),
  .rd_cc_ins(rd_cc_ins), .rd_cc_rem(rd_cc_rem), .rd_underflow(rd_underflow)
);

// File: tb/tb_ccbuf_top.sv
`timescale 1ns/1ps
module tb_ccbuf_top;
  logic       wr_clk = 1'b0, rd_clk = 1'b0, rd_run = 1'b1;
  logic       wr_rst = 1'b1, rd_rst = 1'b1;
  logic       wr_valid = 1'b0, wr_k = 1'b0, strip_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_overflow, rd_valid, rd_k, rd_cc_ins, rd_cc_rem, rd_underflow;
  logic [7:0] rd_data;

  int n_chk = 0, n_fail = 0;
  logic [8:0] got [0:255];
  logic [8:0] expv [0:255];
  int got_n = 0, exp_n = 0, ins_cnt = 0, rem_cnt = 0, rem_at = -1;

  ccbuf_top dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_k(wr_k), .wr_overflow(wr_overflow), .rd_clk(rd_clk), .rd_rst(rd_rst),
    .strip_en(strip_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_k(rd_k),
    .rd_cc_ins(rd_cc_ins), .rd_cc_rem(rd_cc_rem), .rd_underflow(rd_underflow)
  );

  always #2 wr_clk = ~wr_clk;            // 250 MHz write clock
  initial forever begin                  // gated read clock, 6 ns period
    #3;
    if (rd_run) rd_clk = ~rd_clk;
  end

  always @(negedge rd_clk) begin
    if (!rd_rst) begin
      if (rd_cc_ins) ins_cnt++;
      if (rd_cc_rem) begin
        rem_cnt++;
        rem_at = got_n;
      end
      if (rd_valid && got_n < 256) begin
        got[got_n] = {rd_k, rd_data};
        got_n++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit strip);
    rd_run = 1'b1;
    strip_en = strip;
    wr_valid = 1'b0;
    wr_rst = 1'b1;
    rd_rst = 1'b1;
    repeat (10) @(negedge wr_clk);
    wr_rst = 1'b0;
    rd_rst = 1'b0;
    got_n = 0; exp_n = 0; ins_cnt = 0; rem_cnt = 0; rem_at = -1;
    repeat (6) @(negedge wr_clk);
    rd_run = 1'b0;                       // let writes accumulate
    repeat (2) @(negedge wr_clk);
  endtask

  task automatic put(input logic [7:0] d, input logic k, input int copies);
    @(negedge wr_clk);
    wr_valid = 1'b1;
    wr_data = d;
    wr_k = k;
    for (int c = 0; c < copies; c++) begin
      expv[exp_n] = {k, d};
      exp_n++;
    end
  endtask

  task automatic put_seq(input int copies);
    int base;
    base = exp_n;
    put(8'hBC, 1'b1, 0); put(8'h95, 1'b0, 0);
    put(8'hB5, 1'b0, 0); put(8'hB5, 1'b0, 0);
    for (int c = 0; c < copies; c++) begin
      expv[exp_n]   = {1'b1, 8'hBC};
      expv[exp_n+1] = {1'b0, 8'h95};
      expv[exp_n+2] = {1'b0, 8'hB5};
      expv[exp_n+3] = {1'b0, 8'hB5};
      exp_n += 4;
    end
    if (base < 0) exp_n = 0;
  endtask

  task automatic put_data(input int n, input int seed);
    for (int i = 0; i < n; i++) put(8'((i * 13 + seed) & 8'h7F), 1'b0, 1);
  endtask

  task automatic end_writes();
    @(negedge wr_clk);
    wr_valid = 1'b0;
    repeat (12) @(negedge wr_clk);
  endtask

  task automatic drain();
    rd_run = 1'b1;
    repeat (400) @(negedge wr_clk);
  endtask

  task automatic compare(input string req);
    int bad;
    bad = 0;
    check(got_n == exp_n, req, "output symbol count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (got[i] != expv[i]) begin
        if (bad == 0) check(1'b0, req, $sformatf("symbol %0d", i), got[i], expv[i]);
        bad++;
      end
    if (bad == 0) check(1'b1, req, "stream", 0, 0);
  endtask

  // R1, R8: quiet state after reset, no underflow before any data
  task automatic t_reset();
    do_reset(1'b0);
    rd_run = 1'b1;
    repeat (20) @(negedge wr_clk);
    check(!rd_valid, "R1", "rd_valid after reset", rd_valid, 0);
    check(!wr_overflow, "R1", "wr_overflow after reset", wr_overflow, 0);
    check(!rd_underflow, "R8", "rd_underflow before first read", rd_underflow, 0);
    check(got_n == 0, "R1", "symbols seen after reset", got_n, 0);
  endtask

  // R2, R8: plain stream, control flags preserved, then underflow on drain
  task automatic t_basic();
    do_reset(1'b0);
    for (int i = 0; i < 20; i++) put(8'(i * 13 + 1), (i % 5) == 0, 1);
    end_writes();
    drain();
    compare("R2");
    check(rd_underflow, "R8", "rd_underflow after drain", rd_underflow, 1);
  endtask

  // R5: low fill repeats one whole pattern
  task automatic t_repeat();
    do_reset(1'b0);
    put_data(4, 3);
    put_seq(2);
    put_data(4, 40);
    end_writes();
    drain();
    compare("R5");
    check(ins_cnt == 1, "R5", "insert pulses", ins_cnt, 1);
    check(rem_cnt == 0, "R5", "remove pulses", rem_cnt, 0);
  endtask

  // R3: broken patterns at low fill pass through unchanged
  task automatic t_partial();
    do_reset(1'b0);
    put_data(2, 5);
    put(8'hBC, 1'b1, 1); put(8'h95, 1'b0, 1); put(8'hB5, 1'b0, 1); put(8'h00, 1'b0, 1);
    put_data(2, 9);
    put(8'hBC, 1'b0, 1); put(8'h95, 1'b0, 1); put(8'hB5, 1'b0, 1); put(8'hB5, 1'b0, 1);
    put(8'hBC, 1'b1, 1); put(8'h95, 1'b1, 1); put(8'hB5, 1'b0, 1); put(8'hB5, 1'b0, 1);
    put_data(2, 21);
    end_writes();
    drain();
    compare("R3");
    check(ins_cnt == 0, "R3", "insert pulses on broken patterns", ins_cnt, 0);
  endtask

  // R4: 49 stored (> 48) -> pattern dropped, next symbol marked
  task automatic t_drop();
    do_reset(1'b0);
    put_data(49, 2);
    put_seq(0);
    put_data(3, 77);
    end_writes();
    drain();
    compare("R4");
    check(rem_cnt == 1, "R4", "remove pulses", rem_cnt, 1);
    check(rem_at == 49, "R4", "index of marked symbol", rem_at, 49);
    check(ins_cnt == 0, "R4", "insert pulses", ins_cnt, 0);
  endtask

  // R4 boundary: exactly 48 stored -> pattern kept; 16 unread -> no repeat (R5)
  task automatic t_keep48();
    do_reset(1'b0);
    put_data(48, 4);
    put_seq(1);
    put_data(12, 60);
    end_writes();
    drain();
    compare("R4");
    check(rem_cnt == 0, "R4", "remove pulses at 48", rem_cnt, 0);
    check(ins_cnt == 0, "R5", "insert pulses at 16 unread", ins_cnt, 0);
  endtask

  // R6: strip hides the pattern and its repeat, broken pattern still visible
  task automatic t_strip();
    do_reset(1'b1);
    put_data(4, 6);
    put_seq(0);
    put_data(4, 30);
    put(8'hBC, 1'b1, 1); put(8'h95, 1'b0, 1); put(8'hB5, 1'b0, 1); put(8'h00, 1'b0, 1);
    end_writes();
    drain();
    compare("R6");
    check(ins_cnt == 1, "R6", "hidden repeat still signalled", ins_cnt, 1);
  endtask

  // R7: 70 symbols into 64 entries -> 6 lost, sticky flag
  task automatic t_overflow();
    do_reset(1'b0);
    put_data(64, 1);
    for (int i = 0; i < 6; i++) put(8'(i + 200), 1'b0, 0);
    end_writes();
    check(wr_overflow, "R7", "wr_overflow after loss", wr_overflow, 1);
    drain();
    compare("R7");
    check(wr_overflow, "R7", "wr_overflow still set after drain", wr_overflow, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_repeat();
    t_partial();
    t_drop();
    t_keep48();
    t_strip();
    t_overflow();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule